// File: doc/BRIEF.md
# Two-Rank Converter Code Register

This block is the digital front end of a 16-bit converter with a parallel data bus. A first rank, the staging register, captures words from the bus. A second rank, the output register, holds the code that the converter would turn into a voltage. Two address inputs and an active-low write strobe choose which rank takes data. So a host can stage a new word early and then move it to the output at a chosen moment. A third address pattern lets the bus pass straight through to both ranks while the strobe is held low.

Codes are two's complement. An active-low clear drives the output register to code 0x0000 at once, without waiting for a clock. In two's complement that code is mid-scale. The clear leaves the staging register alone. The block also gives an offset-binary copy of the output code, for checking and for converters that expect unsigned input.

The write strobe passes through a two-stage synchroniser. A state machine follows the synchronised strobe through three states:
- `ST_IDLE`: strobe inactive, nothing loads.
- `ST_HELD`: strobe asserted with an address other than both-low. The rank update waits for the strobe's release.
- `ST_FLOW`: strobe asserted with both address lines low. Both ranks take the bus on every clock.

The transitions are:
- `IDLE→HELD` and `IDLE→FLOW` when the synchronised strobe goes low. The address decides which of the two.
- `HELD→FLOW` and `FLOW→HELD` when the address changes while the strobe is still low.
- `HELD→IDLE` and `FLOW→IDLE` when the strobe is released. This is the commit. The address present at the commit edge is decoded once, and the chosen rank or ranks load.

Address, data and clear are not synchronised. Address and data must stay stable from the falling strobe until three clock edges after it rises.

Top module: `dac_code_front`

## Requirements
- R1: While `rst_n` is low, both ranks read 0x0000 and `code_ubin` reads 0x8000.
- R2: With `sel_a0`=0 and `sel_a1`=1, a write strobe (low, then high) loads the bus word into the staging register within three clock edges after `wr_n` rises. The output register does not change.
- R3: With `sel_a0`=1 and `sel_a1`=0, a write strobe copies the staging register into the output register within three clock edges after `wr_n` rises. The staging register does not change.
- R4: With `sel_a0`=1 and `sel_a1`=1, a write strobe changes neither rank.
- R5: With `sel_a0`=0, `sel_a1`=0 and `wr_n` held low, once the strobe has been low for three clock edges, both ranks follow every bus change within one clock edge. Both keep the last bus word after `wr_n` rises.
- R6: While `clr_n` is low, the output register reads 0x0000 (two's complement mid-scale). This takes effect without a clock edge and holds whatever the address and strobe do.
- R7: Clear leaves the staging register unchanged, and a staging load still works during clear. After `clr_n` returns high, the output register stays at 0x0000 until the next copy or pass-through write.
- R8: While `wr_n` stays high, neither rank changes, whatever the bus and address do.
- R9: `code_ubin` always equals `code_out` with bit 15 inverted (offset binary).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_d | input | 16 | Parallel data word, two's complement |
| sel_a0 | input | 1 | Address line 0 |
| sel_a1 | input | 1 | Address line 1 |
| wr_n | input | 1 | Active-low write strobe, asynchronous to `clk` |
| clr_n | input | 1 | Asynchronous active-low clear of the output register |
| code_stage | output | 16 | Staging register contents |
| code_out | output | 16 | Output register contents, two's complement |
| code_ubin | output | 16 | Output code in offset binary |

## Verification
The bench goes after these cases:
- A clear asserted between clock edges. A design that waited for a clock to clear would still show the old code one nanosecond later.
- A copy write issued while clear is held. A design that let the load beat the clear would show the staged word instead of mid-scale.
- The no-op address pattern and idle bus changes. A wrong decode or a level-sensitive load would corrupt one of the ranks.
- Pass-through mode with several bus changes under one long strobe. A design that only latched on release would lag the bus until the strobe rose.

// File: rtl/dac_code_pkg.sv
package dac_code_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HELD = 2'd1,
        ST_FLOW = 2'd2
    } wr_state_e;

    typedef struct packed {
        logic ld_stage;
        logic ld_out;
        logic out_from_bus;
    } rank_ctl_t;

    localparam rank_ctl_t CTL_NONE = '{ld_stage: 1'b0, ld_out: 1'b0, out_from_bus: 1'b0};

    function automatic rank_ctl_t decode_sel(input logic a0, input logic a1);
        rank_ctl_t c;
        c = CTL_NONE;
        unique case ({a1, a0})
            2'b00: begin c.ld_stage = 1'b1; c.ld_out = 1'b1; c.out_from_bus = 1'b1; end
            2'b10: c.ld_stage = 1'b1;
            2'b01: c.ld_out = 1'b1;
            2'b11: c = CTL_NONE;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/strobe_sync.sv
module strobe_sync #(
    parameter int STAGES    = 2,
    parameter bit RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic d_sync
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] shreg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= RESET_VAL;
                else        shreg <= d_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) shreg <= {STAGES{RESET_VAL}};
                else        shreg <= {shreg[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign d_sync = shreg[LAST];
endmodule

// File: rtl/write_fsm.sv
module write_fsm
    import dac_code_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      wr_n_s,
    input  logic      sel_a0,
    input  logic      sel_a1,
    output rank_ctl_t ctl
);
    wr_state_e st_q, st_d;
    logic      sel_pass;

    assign sel_pass = !sel_a0 && !sel_a1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (!wr_n_s) st_d = sel_pass ? ST_FLOW : ST_HELD;
            ST_HELD: begin
                if (wr_n_s)        st_d = ST_IDLE;
                else if (sel_pass) st_d = ST_FLOW;
            end
            ST_FLOW: begin
                if (wr_n_s)         st_d = ST_IDLE;
                else if (!sel_pass) st_d = ST_HELD;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_comb begin
        ctl = CTL_NONE;
        unique case (st_q)
            ST_IDLE: ctl = CTL_NONE;
            ST_HELD: if (wr_n_s) ctl = decode_sel(sel_a0, sel_a1);
            ST_FLOW: begin
                if (wr_n_s) ctl = decode_sel(sel_a0, sel_a1);
                else        ctl = decode_sel(1'b0, 1'b0);
            end
            default: ctl = CTL_NONE;
        endcase
    end

    AST_LOAD_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl.ld_stage || ctl.ld_out) |-> (st_q != ST_IDLE)); // R8
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && wr_n_s) |=> (st_q == ST_IDLE)); // R8
    AST_OUT_LOAD_A1_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctl.ld_out |-> !sel_a1); // R3
    AST_NOOP_SEL: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_a0 && sel_a1) |-> !(ctl.ld_stage || ctl.ld_out)); // R4
endmodule

// File: rtl/code_ranks.sv
module code_ranks
    import dac_code_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_n,
    input  rank_ctl_t         ctl,
    input  logic [DATA_W-1:0] bus_d,
    output logic [DATA_W-1:0] stage_q,
    output logic [DATA_W-1:0] out_q
);
    localparam logic [DATA_W-1:0] MID_CODE = '0;

    logic              out_rst_n;
    logic [DATA_W-1:0] out_src;

    assign out_rst_n = rst_n & clr_n;
    assign out_src   = ctl.out_from_bus ? bus_d : stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            stage_q <= '0;
        else if (ctl.ld_stage) stage_q <= bus_d;
    end

    always_ff @(posedge clk or negedge out_rst_n) begin
        if (!out_rst_n)      out_q <= MID_CODE;
        else if (ctl.ld_out) out_q <= out_src;
    end

    AST_CLR_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (out_q == MID_CODE)); // R6
    AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ctl.ld_stage |=> $stable(stage_q)); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_n && !ctl.ld_out) |=> (out_q == $past(out_q) || out_q == MID_CODE)); // R2
endmodule

// File: rtl/dac_code_front.sv
module dac_code_front
    import dac_code_pkg::*;
#(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] bus_d,
    input  logic              sel_a0,
    input  logic              sel_a1,
    input  logic              wr_n,
    input  logic              clr_n,
    output logic [DATA_W-1:0] code_stage,
    output logic [DATA_W-1:0] code_out,
    output logic [DATA_W-1:0] code_ubin
);
    localparam int MSB = DATA_W - 1;

    logic      wr_n_s;
    rank_ctl_t ctl;

    strobe_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_wr_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (wr_n),
        .d_sync  (wr_n_s)
    );

    write_fsm u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_n_s (wr_n_s),
        .sel_a0 (sel_a0),
        .sel_a1 (sel_a1),
        .ctl    (ctl)
    );

    code_ranks #(.DATA_W(DATA_W)) u_ranks (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_n   (clr_n),
        .ctl     (ctl),
        .bus_d   (bus_d),
        .stage_q (code_stage),
        .out_q   (code_out)
    );

    assign code_ubin = {~code_out[MSB], code_out[MSB-1:0]};

    AST_UBIN_MIDSCALE: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_n |-> (code_ubin == {1'b1, {(DATA_W-1){1'b0}}})); // R9
endmodule

// File: tb/dac_code_front_bench.sv
`timescale 1ns/1ps
module dac_code_front_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_d = '0;
    logic        sel_a0 = 1'b1, sel_a1 = 1'b1, wr_n = 1'b1, clr_n = 1'b1;
    logic [15:0] code_stage, code_out, code_ubin;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [15:0] exp_stage = '0, exp_out = '0;

    always #10 clk = ~clk;

    dac_code_front u_dac_code_front (
        .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .sel_a0(sel_a0), .sel_a1(sel_a1),
        .wr_n(wr_n), .clr_n(clr_n), .code_stage(code_stage), .code_out(code_out),
        .code_ubin(code_ubin)
    );

    function automatic logic [15:0] f_ubin(input logic [15:0] c);
        return {~c[15], c[14:0]};
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        chk({tag, " stage"}, code_stage, exp_stage);
        chk({tag, " out"}, code_out, exp_out);
        chk({"R9 ubin after ", tag}, code_ubin, f_ubin(exp_out));
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // strobe with address/data held stable throughout
    task automatic strobe(input logic a0, input logic a1, input logic [15:0] d);
        @(negedge clk);
        sel_a0 = a0; sel_a1 = a1; bus_d = d;
        wr_n = 1'b0;
        wait_n(4);
        wr_n = 1'b1;
        wait_n(4);
        unique case ({a1, a0})
            2'b10: exp_stage = d;
            2'b01: if (clr_n) exp_out = exp_stage;
            2'b00: begin exp_stage = d; if (clr_n) exp_out = d; end
            2'b11: ;
        endcase
        sel_a0 = 1'b1; sel_a1 = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [15:0] w;
        void'($urandom(32'd715));
        wait_n(3);
        chk("R1 reset stage", code_stage, 16'h0000);
        chk("R1 reset out", code_out, 16'h0000);
        chk("R1 reset ubin", code_ubin, 16'h8000);
        rst_n = 1'b1;
        wait_n(2);

        strobe(1'b0, 1'b1, 16'h7FFF);
        check_all("R2 stage load");
        strobe(1'b1, 1'b0, 16'h1234);
        check_all("R3 copy");
        strobe(1'b0, 1'b1, 16'h8000);
        check_all("R2 second load");
        strobe(1'b1, 1'b1, 16'hDEAD);
        check_all("R4 noop");

        // R8: idle bus and address churn with strobe high
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            bus_d = 16'($urandom); sel_a0 = 1'($urandom); sel_a1 = 1'($urandom);
        end
        wait_n(2);
        check_all("R8 idle");

        // R5: pass-through with bus changes under one strobe
        @(negedge clk);
        sel_a0 = 1'b0; sel_a1 = 1'b0; bus_d = 16'h0F0F; wr_n = 1'b0;
        wait_n(4);
        chk("R5 flow out", code_out, 16'h0F0F);
        for (int i = 0; i < 4; i++) begin
            w = 16'($urandom);
            bus_d = w;
            wait_n(1);
            chk("R5 flow stage follows", code_stage, w);
            chk("R5 flow out follows", code_out, w);
        end
        wr_n = 1'b1;
        wait_n(4);
        exp_stage = w; exp_out = w;
        check_all("R5 flow release");
        sel_a0 = 1'b1; sel_a1 = 1'b1;

        // R6/R7: clear between edges
        strobe(1'b0, 1'b1, 16'hA5A5);
        @(negedge clk);
        #3 clr_n = 1'b0;
        #1;
        chk("R6 clear immediate", code_out, 16'h0000);
        chk("R7 clear keeps stage", code_stage, 16'hA5A5);
        chk("R9 clear ubin", code_ubin, 16'h8000);
        exp_out = '0;
        strobe(1'b1, 1'b0, 16'h0000);
        check_all("R6 copy during clear");
        strobe(1'b0, 1'b1, 16'h3C3C);
        check_all("R7 stage load during clear");
        @(negedge clk);
        clr_n = 1'b1;
        wait_n(5);
        check_all("R7 after clear release");
        strobe(1'b1, 1'b0, 16'h0000);
        check_all("R7 copy after clear");

        // constrained random mix
        for (int k = 0; k < 60; k++) begin
            int op;
            op = int'($urandom % 6);
            w = 16'($urandom);
            unique case (op)
                0, 1: strobe(1'b0, 1'b1, w);
                2:    strobe(1'b1, 1'b0, w);
                3:    strobe(1'b1, 1'b1, w);
                4:    strobe(1'b0, 1'b0, w);
                default: begin
                    @(negedge clk);
                    clr_n = 1'b0; exp_out = '0;
                    wait_n(2);
                    clr_n = 1'b1;
                    wait_n(2);
                end
            endcase
            check_all("R2 R3 R4 R5 R6 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule